// File: doc/BRIEF.md
# Interlocked Request/Acknowledge Bus Fabric

This block joins a single processor-side master to a set of memory-mapped slaves (twelve by default) over a 16-bit address, a 16-bit write bus and a separate 16-bit read bus. None of these buses is tristated. The master presents an address, write data and a direction flag, then raises its request. The fabric decodes the upper address byte into a single one-hot slave strobe and forwards the latched address and write data to every slave. It then waits as long as the selected slave needs. It returns that slave's read data and acknowledge to the master through a select-steered return path.

Each transfer uses four phases, and every edge waits for the opposite side. The request rises, the acknowledge rises, the request falls, and the acknowledge falls. Because of this interlock, a slave can add any number of wait states. Registers sit on both the outbound strobe path and the inbound acknowledge and data path, so no combinational route runs from the master request to a slave response. An address whose upper byte matches no slave base is answered by an internal default responder. That responder acknowledges with zero data and a decode-error flag, so the master never hangs. A parameter selects whether the read return is a select-driven multiplexer or a plain OR of all slave outputs.

Top module: `hs_bus_fabric`

## Requirements
- R1: After reset, `m_ack`, `m_derr` and every `s_req` bit are low and `m_rdata` is zero.
- R2: Slave i is selected when `m_addr[15:8]` equals byte i of `BASES` (default: slave i has base i, so upper bytes 0x00 to 0x0B are mapped). Only bit i of `s_req` rises for that transfer.
- R3: While any `s_req` bit is high, `s_addr`, `s_we` and `s_wdata` carry the master's address, direction (1 = write) and write data of the transfer in progress, and they stay stable.
- R4: Data written to a slave location is returned by a later read of the same address.
- R5: In multiplexer return mode, `m_rdata` comes only from the selected slave. Whatever the unselected slaves drive is ignored.
- R6: `m_ack` does not rise until the selected slave acknowledges, however many wait cycles the slave inserts.
- R7: `m_ack` stays high while `m_req` stays high. `s_req` falls only after `m_req` has fallen. `m_ack` falls only after the slave's acknowledge has fallen.
- R8: A transfer to an unmapped upper byte raises no `s_req` bit. It is completed with `m_ack` high, `m_rdata` zero and `m_derr` high.
- R9: `m_derr` is low for every transfer to a mapped slave, including the first one after a decode error.
- R10: `s_req` rises exactly one cycle after the cycle in which `m_req` is first seen. `m_ack` rises exactly one cycle after the slave acknowledge is first seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 1 | Master request |
| m_we | input | 1 | Master direction, 1 = write |
| m_addr | input | 16 | Master address |
| m_wdata | input | 16 | Master write data |
| m_ack | output | 1 | Acknowledge to the master |
| m_rdata | output | 16 | Read data to the master, valid while `m_ack` is high |
| m_derr | output | 1 | Decode error, valid while `m_ack` is high |
| s_req | output | 12 | One-hot request strobe per slave |
| s_we | output | 1 | Forwarded direction |
| s_addr | output | 16 | Forwarded address |
| s_wdata | output | 16 | Forwarded write data |
| s_ack | input | 12 | Acknowledge from each slave |
| s_rdata | input | 192 | Read data from each slave, slave i in bits [16i+15:16i] |

## Verification
The bench models twelve slaves. Each inserts a different number of wait cycles, and one stalls for twenty. While a slave is not acknowledging, it drives a distinctive nonzero pattern, so a return path that ORed or mis-steered the data would corrupt the read value. Each master transfer holds its request for zero to three extra cycles after the acknowledge. Against this, a fabric that dropped `m_ack` early, or released the slave strobe before the request fell, is reported. Unmapped accesses include the first byte above the last base, followed at once by a good read. These catch a fabric that strobes a slave on a miss, returns stale data, or leaves the error flag set. Cycle stamps on every strobe and acknowledge edge expose a missing or doubled register stage.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,   // waiting for a master request
        ST_WAIT,   // strobe out, waiting for the slave acknowledge
        ST_HOLD,   // acknowledge to master, waiting for request to fall
        ST_REL     // strobe dropped, waiting for slave acknowledge to fall
    } hsb_state_e;

endpackage

// File: rtl/hsb_decoder.sv
module hsb_decoder #(
    parameter int N_SLV = 12,
    parameter int SW    = 8,
    parameter logic [N_SLV*SW-1:0] BASES = '0
) (
    input  logic [SW-1:0]    hi_i,
    output logic [N_SLV-1:0] sel_o,
    output logic             miss_o
);

    always_comb begin
        for (int i = 0; i < N_SLV; i++) begin
            sel_o[i] = (hi_i == BASES[i*SW +: SW]);
        end
        miss_o = (sel_o == '0);
    end

    // R2: distinct bases give at most one match for any upper byte
    always_comb begin
        a_r2_sel_onehot: assert ($onehot0(sel_o))
            else $error("R2: decoder matched more than one slave");
    end

    initial begin
        for (int i = 0; i < N_SLV; i++) begin
            for (int j = i + 1; j < N_SLV; j++) begin
                a_r2_unique_base: assert (BASES[i*SW +: SW] != BASES[j*SW +: SW])
                    else $error("R2: slaves %0d and %0d share a base", i, j);
            end
        end
    end

endmodule

// File: rtl/hsb_return.sv
module hsb_return #(
    parameter int N_SLV     = 12,
    parameter int DW        = 16,
    parameter bit OR_RETURN = 1'b0
) (
    input  logic [N_SLV-1:0]    sel_i,
    input  logic [N_SLV-1:0]    s_ack_i,
    input  logic [N_SLV*DW-1:0] s_rdata_i,
    output logic                ack_o,
    output logic [DW-1:0]       rdata_o
);

    // acknowledge is always gated by the latched select
    assign ack_o = |(s_ack_i & sel_i);

    generate
        if (OR_RETURN) begin : g_or
            // slaves zero their own outputs when not selected
            always_comb begin
                rdata_o = '0;
                for (int i = 0; i < N_SLV; i++) begin
                    rdata_o = rdata_o | s_rdata_i[i*DW +: DW];
                end
            end
        end else begin : g_mux
            always_comb begin
                rdata_o = '0;
                for (int i = 0; i < N_SLV; i++) begin
                    rdata_o = rdata_o | (s_rdata_i[i*DW +: DW] & {DW{sel_i[i]}});
                end
            end
        end
    endgenerate

endmodule

// File: rtl/hsb_ctrl.sv
module hsb_ctrl
    import hsb_pkg::*;
#(
    parameter int N_SLV = 12,
    parameter int AW    = 16,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             m_req_i,
    input  logic             m_we_i,
    input  logic [AW-1:0]    m_addr_i,
    input  logic [DW-1:0]    m_wdata_i,
    input  logic [N_SLV-1:0] dec_sel_i,
    input  logic             dec_miss_i,
    input  logic             ack_ret_i,
    input  logic [DW-1:0]    rdata_ret_i,
    output logic [N_SLV-1:0] sel_o,
    output logic [N_SLV-1:0] s_req_o,
    output logic             s_we_o,
    output logic [AW-1:0]    s_addr_o,
    output logic [DW-1:0]    s_wdata_o,
    output logic             m_ack_o,
    output logic             m_derr_o,
    output logic [DW-1:0]    m_rdata_o
);

    typedef struct packed {
        hsb_state_e       st;
        logic [N_SLV-1:0] sel;
        logic [N_SLV-1:0] sreq;
        logic             err;
        logic             we;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    wdata;
        logic             ack;
        logic             derr;
        logic [DW-1:0]    rdata;
    } ctrl_t;

    ctrl_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (m_req_i) begin
                    r_d.sel   = dec_sel_i;
                    r_d.sreq  = dec_sel_i;
                    r_d.err   = dec_miss_i;
                    r_d.we    = m_we_i;
                    r_d.addr  = m_addr_i;
                    r_d.wdata = m_wdata_i;
                    r_d.st    = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (r_q.err) begin
                    r_d.ack   = 1'b1;
                    r_d.derr  = 1'b1;
                    r_d.rdata = '0;
                    r_d.st    = ST_HOLD;
                end else if (ack_ret_i) begin
                    r_d.ack   = 1'b1;
                    r_d.rdata = rdata_ret_i;
                    r_d.st    = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!m_req_i) begin
                    r_d.sreq = '0;
                    r_d.st   = ST_REL;
                end
            end
            ST_REL: begin
                if (!ack_ret_i) begin
                    r_d.ack  = 1'b0;
                    r_d.derr = 1'b0;
                    r_d.sel  = '0;
                    r_d.err  = 1'b0;
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sel_o     = r_q.sel;
    assign s_req_o   = r_q.sreq;
    assign s_we_o    = r_q.we;
    assign s_addr_o  = r_q.addr;
    assign s_wdata_o = r_q.wdata;
    assign m_ack_o   = r_q.ack;
    assign m_derr_o  = r_q.derr;
    assign m_rdata_o = r_q.rdata;

    // R2: never more than one slave strobed
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_req_o));

    // R3: forwarded address is stable while a strobe is held
    a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (|s_req_o) |=> (!(|s_req_o) || $stable(s_addr_o)));

    // R7: acknowledge holds while the request holds
    a_r7_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (m_ack_o && m_req_i) |=> m_ack_o);

    // R7: strobe released only after the master request fell
    a_r7_strobe_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|s_req_o) |-> !$past(m_req_i));

    // R7: master acknowledge drops only after the slave acknowledge dropped
    a_r7_ack_after_slave: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(m_ack_o) |-> !$past(ack_ret_i));

    // R8: decode error only with an acknowledge and zero data
    a_r8_derr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        m_derr_o |-> (m_ack_o && (m_rdata_o == '0)));

    // R10: a good acknowledge follows a registered slave acknowledge
    a_r10_ack_registered: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(m_ack_o) && !m_derr_o) |-> $past(ack_ret_i));

endmodule

// File: rtl/hs_bus_fabric.sv
module hs_bus_fabric #(
    parameter int N_SLV = 12,
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int SW    = 8,
    parameter logic [N_SLV*SW-1:0] BASES = 96'h0B0A_0908_0706_0504_0302_0100,
    parameter bit OR_RETURN = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                m_req,
    input  logic                m_we,
    input  logic [AW-1:0]       m_addr,
    input  logic [DW-1:0]       m_wdata,
    output logic                m_ack,
    output logic [DW-1:0]       m_rdata,
    output logic                m_derr,
    output logic [N_SLV-1:0]    s_req,
    output logic                s_we,
    output logic [AW-1:0]       s_addr,
    output logic [DW-1:0]       s_wdata,
    input  logic [N_SLV-1:0]    s_ack,
    input  logic [N_SLV*DW-1:0] s_rdata
);

    localparam int HI_LSB = AW - SW;

    logic [N_SLV-1:0] dec_sel;
    logic             dec_miss;
    logic [N_SLV-1:0] sel_q;
    logic             ack_ret;
    logic [DW-1:0]    rdata_ret;

    hsb_decoder #(.N_SLV(N_SLV), .SW(SW), .BASES(BASES)) u_dec (
        .hi_i   (m_addr[AW-1:HI_LSB]),
        .sel_o  (dec_sel),
        .miss_o (dec_miss)
    );

    hsb_return #(.N_SLV(N_SLV), .DW(DW), .OR_RETURN(OR_RETURN)) u_ret (
        .sel_i     (sel_q),
        .s_ack_i   (s_ack),
        .s_rdata_i (s_rdata),
        .ack_o     (ack_ret),
        .rdata_o   (rdata_ret)
    );

    hsb_ctrl #(.N_SLV(N_SLV), .AW(AW), .DW(DW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .m_req_i     (m_req),
        .m_we_i      (m_we),
        .m_addr_i    (m_addr),
        .m_wdata_i   (m_wdata),
        .dec_sel_i   (dec_sel),
        .dec_miss_i  (dec_miss),
        .ack_ret_i   (ack_ret),
        .rdata_ret_i (rdata_ret),
        .sel_o       (sel_q),
        .s_req_o     (s_req),
        .s_we_o      (s_we),
        .s_addr_o    (s_addr),
        .s_wdata_o   (s_wdata),
        .m_ack_o     (m_ack),
        .m_derr_o    (m_derr),
        .m_rdata_o   (m_rdata)
    );

endmodule

// File: tb/hs_bus_fabric_bench.sv
module hs_bus_fabric_bench;

    localparam int N  = 12;
    localparam int AW = 16;
    localparam int DW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            m_req = 1'b0;
    logic            m_we = 1'b0;
    logic [AW-1:0]   m_addr = '0;
    logic [DW-1:0]   m_wdata = '0;
    logic            m_ack;
    logic [DW-1:0]   m_rdata;
    logic            m_derr;
    logic [N-1:0]    s_req;
    logic            s_we;
    logic [AW-1:0]   s_addr;
    logic [DW-1:0]   s_wdata;
    logic [N-1:0]    s_ack;
    logic [N*DW-1:0] s_rdata;

    always #5 clk = ~clk;

    hs_bus_fabric u_hs_bus_fabric (
        .clk(clk), .rst_n(rst_n),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_ack(m_ack), .m_rdata(m_rdata), .m_derr(m_derr),
        .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
        .s_ack(s_ack), .s_rdata(s_rdata)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int wait_of(input int i);
        return (i == 5) ? 20 : (i % 4);
    endfunction

    // slave models: wait states, 4 words each, junk on the bus when idle
    for (genvar i = 0; i < N; i++) begin : g_slv
        logic [DW-1:0] mem [4];
        logic [DW-1:0] rd;
        logic [4:0]    cnt;
        logic          ack;
        always @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ack <= 1'b0;
                cnt <= '0;
                rd  <= '0;
                for (int k = 0; k < 4; k++) mem[k] <= 16'(i * 256 + k);
            end else if (s_req[i] && !ack) begin
                if (int'(cnt) == wait_of(i)) begin
                    ack <= 1'b1;
                    cnt <= '0;
                    rd  <= mem[s_addr[1:0]];
                    if (s_we) mem[s_addr[1:0]] <= s_wdata;
                end else begin
                    cnt <= cnt + 5'd1;
                end
            end else if (!s_req[i] && ack) begin
                ack <= 1'b0;
            end
        end
        assign s_ack[i] = ack;
        assign s_rdata[i*DW +: DW] = ack ? rd : (16'hDEAD ^ 16'(i));
    end

    typedef struct {
        int            idx;
        bit            we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        bit            derr;
    } item_t;

    item_t         q[$];
    logic [DW-1:0] sh [N][4];

    initial begin
        for (int i = 0; i < N; i++)
            for (int k = 0; k < 4; k++) sh[i][k] = 16'(i * 256 + k);
    end

    // driver: pushes the expected item, then runs the four phases
    task automatic xfer(input bit we, input int idx, input logic [7:0] hi,
                        input logic [1:0] lo, input logic [DW-1:0] wd,
                        input int hold);
        item_t it;
        it.idx   = idx;
        it.we    = we;
        it.addr  = {hi, 6'b0, lo};
        it.wdata = wd;
        it.derr  = (idx < 0);
        it.rdata = (we || idx < 0) ? '0 : sh[idx][lo];
        if (we && idx >= 0) sh[idx][lo] = wd;
        q.push_back(it);
        @(posedge clk); #1;
        m_we = we; m_addr = it.addr; m_wdata = wd; m_req = 1'b1;
        while (!m_ack) begin @(posedge clk); #1; end
        for (int h = 0; h < hold; h++) begin
            @(posedge clk); #1;
            chk(m_ack == 1'b1, "R7 ack held with request", 32'(m_ack), 32'd1);
            if (idx >= 0)
                chk(s_req[idx] == 1'b1, "R7 strobe held with request", 32'(s_req), 32'(1 << idx));
        end
        m_req = 1'b0;
        while (m_ack) begin @(posedge clk); #1; end
        chk(s_req == '0, "R7 strobe low after release", 32'(s_req), 32'd0);
    endtask

    // monitor: scoreboard compare and edge timing
    logic         p_mreq = 1'b0, p_mack = 1'b0;
    logic [N-1:0] p_sreq = '0, p_sack = '0;
    int           mreq_cyc = 0, sack_cyc = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (m_req && !p_mreq) mreq_cyc = cyc;
            if ((|s_req) && !(|p_sreq)) begin
                if (q.size() > 0) begin
                    if (q[0].idx < 0) begin
                        chk(1'b0, "R8 unmapped strobed a slave", 32'(s_req), 32'd0);
                    end else begin
                        chk(s_req == N'(1 << q[0].idx), "R2 select", 32'(s_req), 32'(1 << q[0].idx));
                        chk(s_addr == q[0].addr && s_we == q[0].we && s_wdata == q[0].wdata,
                            "R3 forwarded fields", {s_addr, s_wdata}, {q[0].addr, q[0].wdata});
                    end
                end
                chk(cyc == mreq_cyc + 1, "R10 strobe latency", 32'(cyc - mreq_cyc), 32'd1);
            end
            if ((s_ack & ~p_sack) != '0) sack_cyc = cyc;
            if (m_ack && !p_mack) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R6 acknowledge with nothing pending", 32'd1, 32'd0);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    if (!it.we)
                        chk(m_rdata == it.rdata, "R4/R5 read data", 32'(m_rdata), 32'(it.rdata));
                    chk(m_derr == it.derr, it.derr ? "R8 decode error" : "R9 no error",
                        32'(m_derr), 32'(it.derr));
                    if (it.idx >= 0)
                        chk(cyc == sack_cyc + 1, "R6/R10 ack latency", 32'(cyc - sack_cyc), 32'd1);
                end
            end
            p_mreq = m_req; p_mack = m_ack; p_sreq = s_req; p_sack = s_ack;
        end
    end

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R6 watchdog: actual=hang expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(m_ack == 1'b0 && m_derr == 1'b0, "R1 reset flags", {m_ack, m_derr}, 32'd0);
        chk(s_req == '0, "R1 reset strobes", 32'(s_req), 32'd0);
        chk(m_rdata == '0, "R1 reset data", 32'(m_rdata), 32'd0);
        rst_n = 1'b1;

        xfer(1'b0, 0, 8'h00, 2'd0, 16'h0000, 0);     // R5 plain read
        xfer(1'b1, 3, 8'h03, 2'd2, 16'hA5A5, 1);     // R4 write
        xfer(1'b0, 3, 8'h03, 2'd2, 16'h0000, 2);     // R4 read back
        xfer(1'b0, 11, 8'h0B, 2'd3, 16'h0000, 0);    // R2 last slave
        xfer(1'b1, 5, 8'h05, 2'd1, 16'h1234, 3);     // R6 long stall
        xfer(1'b0, 5, 8'h05, 2'd1, 16'h0000, 0);
        xfer(1'b0, -1, 8'h0C, 2'd0, 16'h0000, 2);    // R8 first byte past map
        xfer(1'b0, 1, 8'h01, 2'd1, 16'h0000, 0);     // R9 good read after error
        xfer(1'b1, -1, 8'hFF, 2'd2, 16'hFFFF, 1);    // R8 unmapped write
        xfer(1'b1, 1, 8'h01, 2'd0, 16'h0F0F, 0);     // R9
        for (int i = 0; i < N; i++) begin
            xfer(1'b1, i, 8'(i), 2'(i), 16'hC000 ^ 16'(i * 37), i % 4);
        end
        for (int i = N - 1; i >= 0; i--) begin
            xfer(1'b0, i, 8'(i), 2'(i), 16'h0000, (i + 1) % 4);
        end
        xfer(1'b0, -1, 8'h80, 2'd1, 16'h0000, 0);
        xfer(1'b0, 0, 8'h00, 2'd0, 16'h0000, 0);

        repeat (5) @(posedge clk);
        chk(q.size() == 0, "R6 all transfers completed", 32'(q.size()), 32'd0);
        summary();
        $finish;
    end

endmodule